// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is a single channel of a general-purpose timer. It watches a counter and a reload value that a shared timebase supplies, together with that timebase's overflow and underflow pulses. In compare mode it sets a sticky flag when the counter reaches the channel register. In capture mode it synchronises an external pin, detects the selected edge, copies the counter into the channel register and sets the same flag. A second sticky bit records a capture that arrives before the previous one was serviced.

Software reaches the channel through a two-entry register port. Entry 0 is the channel value. Entry 1 is the status word. Status bits are cleared by writing zero to them. In capture mode, a read of the channel value also clears the flag.

Top module: `cc_channel`

## Requirements
- R1: In compare mode (`cap_mode_i`=0), when the channel register is not above `arr_i` and `cnt_i` equals it, `flag_o` is 1 after the next clock edge.
- R2: In compare mode, when the channel register is above `arr_i`, counter equality is ignored. Instead the flag is set by `unf_i` when `cnt_mode_i`=01 (down), and by `ovf_i` for 00 (up), 10 (up/down) and 11 (treated as up). When the register is not above `arr_i`, the wrap pulses do not set the flag.
- R3: In capture mode the pin passes through two flops before edge detection. For a pin level first sampled at clock edge k, the counter value present just before edge k+2 is stored, and `flag_o` rises at edge k+2 and not earlier.
- R4: `pol_i` selects the capture edge: 00 rising, 01 falling, 11 both, 10 rising. A transition that was not selected changes neither the flag nor the register.
- R5: In capture mode, a read with `rd_en_i`=1 and `rd_addr_i`=0 clears `flag_o` on the next edge. The same read in compare mode leaves the flag unchanged.
- R6: A capture that occurs while `flag_o` is 1, and is not accompanied by a clearing read, sets `ovc_o`. A capture with the flag clear does not set it.
- R7: A write to address 1 clears `flag_o` where data bit 0 is 0, and clears `ovc_o` where data bit 1 is 0. Writing a 1 has no effect on that bit. A hardware set in the same cycle wins over a software clear.
- R8: A write to address 0 loads the channel register in compare mode. In capture mode the write is ignored.
- R9: During reset the channel register, `flag_o` and `ovc_o` are 0.
- R10: `rd_data_o` shows the channel register when `rd_addr_i`=0. When `rd_addr_i`=1 it shows the flag in bit 0, overcapture in bit 1, and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | W | Shared counter value |
| arr_i | input | W | Auto-reload value |
| cnt_mode_i | input | 2 | Count direction: 00 up, 01 down, 10 up/down, 11 up |
| ovf_i | input | 1 | Counter overflow pulse |
| unf_i | input | 1 | Counter underflow pulse |
| cap_mode_i | input | 1 | 1 selects input capture, 0 selects output compare |
| pol_i | input | 2 | Capture edge select |
| cap_in_i | input | 1 | Asynchronous capture pin |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write address: 0 channel value, 1 status |
| wr_data_i | input | W | Write data |
| rd_en_i | input | 1 | Read strobe; clears the flag in capture mode |
| rd_addr_i | input | 1 | Read address |
| rd_data_o | output | W | Read data, combinational on `rd_addr_i` |
| flag_o | output | 1 | Compare-match or capture flag |
| ovc_o | output | 1 | Overcapture flag |

## Verification
A corrupted channel register shows up at once on the read port. In compare mode it also makes the flag appear or disappear one edge after the counter value that should have triggered it. A wrong synchroniser depth or edge decode moves the flag's rising edge away from edge k+2, or changes the captured counter value, so each capture is checked at both edge k+1 and edge k+2. Faults in the clear priority or in the overcapture qualification show in the flag bits on the cycle after the colliding read, write or capture.

// File: rtl/cc_pkg.sv
`timescale 1ns/1ps
package cc_pkg;
  typedef enum logic [1:0] {
    CNT_UP     = 2'b00,
    CNT_DOWN   = 2'b01,
    CNT_CENTER = 2'b10,
    CNT_UP_ALT = 2'b11
  } cnt_mode_e;

  typedef enum logic [1:0] {
    POL_RISE     = 2'b00,
    POL_FALL     = 2'b01,
    POL_RISE_ALT = 2'b10,
    POL_BOTH     = 2'b11
  } pol_e;

  localparam logic ADDR_CCR  = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  localparam int unsigned STAT_FLAG_BIT = 0;
  localparam int unsigned STAT_OVC_BIT  = 1;
  localparam int unsigned STAT_W        = 2;
endpackage

// File: rtl/cc_in_sync.sv
`timescale 1ns/1ps
module cc_in_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] pol_i,
  input  logic       sig_i,
  output logic       edge_o
);
  import cc_pkg::*;

  logic sync_out;
  logic last_q;
  logic rise, fall;

  generate
    if (SYNC_STAGES < 2) begin : g_single
      logic s_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= 1'b0;
        else         s_q <= sig_i;
      end
      assign sync_out = s_q;
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= {s_q[SYNC_STAGES-2:0], sig_i};
      end
      assign sync_out = s_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_out;
  end

  assign rise = sync_out & ~last_q;
  assign fall = ~sync_out & last_q;

  always_comb begin
    unique case (pol_i)
      POL_FALL: edge_o = en_i & fall;
      POL_BOTH: edge_o = en_i & (rise | fall);
      default:  edge_o = en_i & rise;
    endcase
  end
endmodule

// File: rtl/cc_match.sv
`timescale 1ns/1ps
module cc_match #(
  parameter int unsigned W = 16
) (
  input  logic         en_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] arr_i,
  input  logic [W-1:0] ccr_i,
  input  logic [1:0]   cnt_mode_i,
  input  logic         ovf_i,
  input  logic         unf_i,
  output logic         set_o
);
  import cc_pkg::*;

  logic above_reload;
  logic wrap_evt;

  assign above_reload = ccr_i > arr_i;
  // a value beyond reload is never reached: fire at the wrap instead
  assign wrap_evt     = (cnt_mode_i == CNT_DOWN) ? unf_i : ovf_i;
  assign set_o        = en_i & (above_reload ? wrap_evt : (cnt_i == ccr_i));
endmodule

// File: rtl/cc_sticky_flags.sv
`timescale 1ns/1ps
module cc_sticky_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= set_i | (q_o & ~clr_i);
  end
endmodule

// File: rtl/cc_channel.sv
`timescale 1ns/1ps
module cc_channel #(
  parameter int unsigned W           = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] arr_i,
  input  logic [1:0]   cnt_mode_i,
  input  logic         ovf_i,
  input  logic         unf_i,
  input  logic         cap_mode_i,
  input  logic [1:0]   pol_i,
  input  logic         cap_in_i,
  input  logic         wr_en_i,
  input  logic         wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_en_i,
  input  logic         rd_addr_i,
  output logic [W-1:0] rd_data_o,
  output logic         flag_o,
  output logic         ovc_o
);
  import cc_pkg::*;

  logic [W-1:0]      ccr_q;
  logic              cap_edge;
  logic              cmp_set;
  logic              ccr_wr;
  logic              stat_wr;
  logic              rd_clr;
  logic [STAT_W-1:0] st_set, st_clr, st_q;

  cc_in_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cap_mode_i),
    .pol_i  (pol_i),
    .sig_i  (cap_in_i),
    .edge_o (cap_edge)
  );

  cc_match #(.W(W)) u_match (
    .en_i       (~cap_mode_i),
    .cnt_i      (cnt_i),
    .arr_i      (arr_i),
    .ccr_i      (ccr_q),
    .cnt_mode_i (cnt_mode_i),
    .ovf_i      (ovf_i),
    .unf_i      (unf_i),
    .set_o      (cmp_set)
  );

  assign ccr_wr  = wr_en_i & (wr_addr_i == ADDR_CCR) & ~cap_mode_i;
  assign stat_wr = wr_en_i & (wr_addr_i == ADDR_STAT);
  assign rd_clr  = rd_en_i & (rd_addr_i == ADDR_CCR) & cap_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ccr_q <= '0;
    else if (cap_edge) ccr_q <= cnt_i;
    else if (ccr_wr)   ccr_q <= wr_data_i;
  end

  always_comb begin
    st_set = '0;
    st_clr = '0;
    st_set[STAT_FLAG_BIT] = cap_mode_i ? cap_edge : cmp_set;
    st_clr[STAT_FLAG_BIT] = (stat_wr & ~wr_data_i[STAT_FLAG_BIT]) | rd_clr;
    // a capture that lands together with the servicing read is not an overrun
    st_set[STAT_OVC_BIT]  = cap_edge & st_q[STAT_FLAG_BIT] & ~rd_clr;
    st_clr[STAT_OVC_BIT]  = stat_wr & ~wr_data_i[STAT_OVC_BIT];
  end

  cc_sticky_flags #(.N(STAT_W)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (st_set),
    .clr_i  (st_clr),
    .q_o    (st_q)
  );

  assign flag_o = st_q[STAT_FLAG_BIT];
  assign ovc_o  = st_q[STAT_OVC_BIT];

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_CCR) rd_data_o = ccr_q;
    else                       rd_data_o[STAT_W-1:0] = st_q;
  end
endmodule

// File: rtl/cc_channel_chk.sv
`timescale 1ns/1ps
module cc_channel_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cap_mode_i,
  input logic [W-1:0] cnt_i,
  input logic [W-1:0] arr_i,
  input logic [1:0]   cnt_mode_i,
  input logic         ovf_i,
  input logic         unf_i,
  input logic         rd_en_i,
  input logic         rd_addr_i,
  input logic         wr_en_i,
  input logic         wr_addr_i,
  input logic         wr_ovc_bit,
  input logic [W-1:0] ccr_q,
  input logic         cap_edge,
  input logic         flag_o,
  input logic         ovc_o
);
  AST_CMP_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_mode_i && ccr_q <= arr_i && cnt_i == ccr_q) |=> flag_o); // R1

  AST_WRAP_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_mode_i && ccr_q > arr_i &&
     ((cnt_mode_i == 2'b01) ? unf_i : ovf_i)) |=> flag_o); // R2

  AST_CAP_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_edge |=> (ccr_q == $past(cnt_i) && flag_o)); // R3

  AST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_mode_i && rd_en_i && rd_addr_i == 1'b0 && !cap_edge) |=> !flag_o); // R5

  AST_OVC_AFTER_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovc_o) |-> ($past(flag_o) && $past(cap_mode_i))); // R6

  AST_OVC_SW_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i && !wr_ovc_bit && !(cap_edge && flag_o)) |=> !ovc_o); // R7

  AST_CCR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_mode_i && !cap_edge) |=> $stable(ccr_q)); // R8
endmodule

bind cc_channel cc_channel_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cap_mode_i (cap_mode_i),
  .cnt_i      (cnt_i),
  .arr_i      (arr_i),
  .cnt_mode_i (cnt_mode_i),
  .ovf_i      (ovf_i),
  .unf_i      (unf_i),
  .rd_en_i    (rd_en_i),
  .rd_addr_i  (rd_addr_i),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_ovc_bit (wr_data_i[1]),
  .ccr_q      (ccr_q),
  .cap_edge   (cap_edge),
  .flag_o     (flag_o),
  .ovc_o      (ovc_o)
);

// File: tb/sim_cc_channel.sv
`timescale 1ns/1ps
module sim_cc_channel;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] cnt, arr, wr_data, rd_data;
  logic [1:0]   cnt_mode, pol;
  logic         ovf, unf, cap_mode, cap_in, wr_en, wr_addr, rd_en, rd_addr;
  logic         flag, ovc;
  int           checks = 0;
  int           errors = 0;

  always #2.5 clk = ~clk;

  cc_channel #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .arr_i(arr), .cnt_mode_i(cnt_mode),
    .ovf_i(ovf), .unf_i(unf), .cap_mode_i(cap_mode), .pol_i(pol), .cap_in_i(cap_in),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .flag_o(flag), .ovc_o(ovc)
  );

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wreg(input logic a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic toggle(input logic lvl);
    cap_in = lvl;
    repeat (3) step();
  endtask

  function automatic bit edge_hit(input int p, input int lvl);
    if (p == 1) return lvl == 0;
    if (p == 3) return 1'b1;
    return lvl == 1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnt = '0; arr = 4'd15; wr_data = '0; cnt_mode = 2'b00; pol = 2'b00;
    ovf = 1'b0; unf = 1'b0; cap_mode = 1'b0; cap_in = 1'b0;
    wr_en = 1'b0; wr_addr = 1'b0; rd_en = 1'b0; rd_addr = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    rd_addr = 1'b0; #0.1 chk("R9 ccr", rd_data, 0);
    rd_addr = 1'b1; #0.1 chk("R9 status", rd_data, 0);
    chk("R9 flag", flag, 0);
    chk("R9 ovc", ovc, 0);
    rst_n = 1'b1;
    rd_addr = 1'b0;
    step();

    // R1/R2/R8: full compare sweep, two reload values
    for (int a = 0; a < 2; a++) begin
      arr = (a == 0) ? 4'd7 : 4'd15;
      for (int c = 0; c < 16; c++) begin
        wreg(1'b0, c[W-1:0]);
        chk("R8 ccr write", rd_data, c);
        for (int v = 0; v < 16; v++) begin
          cnt = v[W-1:0];
          wr_en = 1'b1; wr_addr = 1'b1; wr_data = '0;
          step();
          wr_en = 1'b0;
          chk((c > arr) ? "R2 equality ignored" : "R1 match", flag,
              (c <= arr && v == c) ? 1 : 0);
        end
      end
    end

    // R2: wrap flagging with register above reload
    arr = 4'd5;
    wreg(1'b0, 4'd9);
    for (int m = 0; m < 4; m++) begin
      for (int e = 0; e < 4; e++) begin
        cnt = '0; cnt_mode = m[1:0]; ovf = e[0]; unf = e[1];
        wr_en = 1'b1; wr_addr = 1'b1; wr_data = '0;
        step();
        wr_en = 1'b0; ovf = 1'b0; unf = 1'b0;
        chk("R2 wrap", flag, (m == 1) ? e[1] : e[0]);
      end
    end
    // R2: register equal to reload ignores the wrap pulse
    wreg(1'b0, 4'd5);
    cnt = '0; cnt_mode = 2'b00; ovf = 1'b1;
    wr_en = 1'b1; wr_addr = 1'b1; wr_data = '0;
    step();
    wr_en = 1'b0; ovf = 1'b0;
    chk("R2 no wrap at equal", flag, 0);

    // R3/R4: capture sweep over polarity and edge direction
    arr = 4'd15;
    for (int p = 0; p < 4; p++) begin
      for (int d = 0; d < 2; d++) begin
        int  base;
        bit  hit;
        cap_mode = 1'b0; pol = p[1:0]; cap_in = ~d[0]; cnt = '0;
        repeat (4) step();
        wreg(1'b0, 4'd15);
        wreg(1'b1, '0);
        cap_mode = 1'b1;
        step();
        base = 3 + 2 * p + d;
        hit  = edge_hit(p, d);
        cnt = base[W-1:0]; cap_in = d[0];
        step();
        cnt = W'(base + 1);
        step();
        cnt = W'(base + 2);
        chk("R3 no early flag", flag, 0);
        step();
        rd_addr = 1'b0;
        chk("R4 edge select flag", flag, hit ? 1 : 0);
        chk("R3 captured value", rd_data, hit ? ((base + 2) % 16) : 15);
        chk("R6 single capture", ovc, 0);
      end
    end

    // R5/R6/R7/R10: overcapture and clearing
    cap_mode = 1'b0; pol = 2'b11; cap_in = 1'b0; cnt = 4'd6;
    repeat (4) step();
    wreg(1'b0, 4'd15);
    wreg(1'b1, '0);
    cap_mode = 1'b1;
    step();
    toggle(1'b1);
    chk("R3 capture flag", flag, 1);
    chk("R6 first capture", ovc, 0);
    rd_addr = 1'b0; #0.1 chk("R3 capture value", rd_data, 6);
    toggle(1'b0);
    chk("R6 overcapture", ovc, 1);
    chk("R6 flag kept", flag, 1);
    rd_addr = 1'b1; #0.1 chk("R10 status word", rd_data, 3);
    rd_en = 1'b1; rd_addr = 1'b0;
    step();
    rd_en = 1'b0;
    chk("R5 read clears flag", flag, 0);
    chk("R5 read keeps ovc", ovc, 1);
    wreg(1'b1, 4'd1);
    chk("R7 ovc cleared", ovc, 0);
    chk("R7 write 1 no set flag", flag, 0);
    toggle(1'b1);
    wreg(1'b1, 4'd2);
    chk("R7 flag cleared", flag, 0);
    chk("R7 write 1 no set ovc", ovc, 0);
    toggle(1'b0);
    chk("R6 no ovc from clear flag", ovc, 0);
    cap_in = 1'b1;
    step();
    step();
    rd_en = 1'b1; rd_addr = 1'b0;
    step();
    rd_en = 1'b0;
    chk("R7 capture beats read clear", flag, 1);
    chk("R6 serviced read no ovc", ovc, 0);
    // R8: write ignored in capture mode
    wreg(1'b0, 4'd9);
    rd_addr = 1'b0; #0.1 chk("R8 write ignored", rd_data, 6);

    // R5: read in compare mode keeps flag
    cap_mode = 1'b0; cnt = 4'd7;
    wreg(1'b0, 4'd4);
    wreg(1'b1, '0);
    chk("R7 clear in compare mode", flag, 0);
    cnt = 4'd4;
    step();
    cnt = 4'd7;
    chk("R1 match late", flag, 1);
    rd_en = 1'b1; rd_addr = 1'b0;
    step();
    rd_en = 1'b0;
    chk("R5 compare read keeps flag", flag, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule